// File: doc/BRIEF.md
# Reset Supervisor with Watchdog

This block produces a system reset from three sources: a supply-good level from an external comparator, a manual reset request sensed on either reset pin, and a watchdog that watches a serial data line for activity. It drives two reset outputs of opposite polarity. The bench or board resolves each pin as the wired combination of the block's own drive and any external driver, and feeds the resolved pin level back to the block, so a push-button or another device can pull either pin to its active level and start a reset.

The supply input passes through a glitch filter. Each rising edge of the filtered supply starts a fixed reset timeout. Manual reset is edge-triggered: an active edge on a pin starts a reset of the same fixed length, however long the pin is then held. The watchdog counts clock cycles while the block is out of reset. Any transition on the monitored data line clears the count, and reaching the period starts a reset. A memory-disable output follows the resolved pin levels, so that an attached memory stays idle while any pin reads active. All intervals are parameters in clock cycles.

Top module: `rst_supervisor`

## Requirements
- R1: While the filtered supply is low, `rst_hi_o` is 1 and `rst_lo_n_o` is 0. This also holds while `rst_n` is low.
- R2: After `supply_ok` rises and stays high, both outputs release exactly GLITCH_CYC+TIMEOUT_CYC clock edges after the first edge that samples it high.
- R3: When `supply_ok` falls and stays low, both outputs assert GLITCH_CYC+1 edges after the first edge that samples it low. No timeout applies.
- R4: A level of `supply_ok` that lasts fewer than GLITCH_CYC cycles is ignored. A short low dip causes no reset. A short high pulse during a supply-low reset does not start the timeout.
- R5: A falling edge on `rst_lo_n_pad` (low = active) asserts both outputs 3 edges after the first edge that samples the new level. Both outputs release TIMEOUT_CYC edges later.
- R6: A rising edge on `rst_hi_pad` (high = active) starts the same reset with the same timing as R5. A single-cycle pulse is enough.
- R7: A manual reset releases after its timeout even while the pin is still held active. The later return of the pin to its inactive level starts no reset.
- R8: With no transition on `sda_in`, the watchdog asserts the resets WDOG_CYC+3 edges after the first edge that samples its last transition.
- R9: Both a rising and a falling transition on `sda_in` clear the watchdog count.
- R10: While reset is asserted, the watchdog does not count. After a release, a timeout comes exactly WDOG_CYC edges later if the line stays quiet.
- R11: `mem_disable` is 1 whenever `rst_hi_pad` is high or `rst_lo_n_pad` is low, 2 edges after the pin changes.
- R12: The block's own drive on the pins does not retrigger it. A reset started by the watchdog lasts exactly TIMEOUT_CYC edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous block reset, active low |
| supply_ok | input | 1 | Supply-good level from the comparator |
| sda_in | input | 1 | Monitored serial data line |
| rst_hi_pad | input | 1 | Resolved level of the active-high reset pin |
| rst_lo_n_pad | input | 1 | Resolved level of the active-low reset pin |
| rst_hi_o | output | 1 | Active-high reset drive |
| rst_lo_n_o | output | 1 | Active-low reset drive |
| mem_disable | output | 1 | High while either reset pin reads active |

## Verification
Each result has a fixed latency from the first edge that samples its stimulus. The filtered supply releases after GLITCH_CYC+TIMEOUT_CYC edges and asserts after GLITCH_CYC+1. A manual edge takes 3 edges, a data-line transition takes WDOG_CYC+3 edges until a watchdog reset, and the memory-disable output follows its pin after 2 edges. The bench drives every input on the falling clock edge and counts whole rising edges before it samples, again on a falling edge. At each boundary it checks the cycle before the change as well as the cycle of the change, so a result that comes one cycle early or one cycle late is reported.

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int TIMEOUT_CYC = 50_000_000,
  parameter int WDOG_CYC    = 400_000_000,
  parameter int GLITCH_CYC  = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic sda_in,
  input  logic rst_hi_pad,
  input  logic rst_lo_n_pad,
  output logic rst_hi_o,
  output logic rst_lo_n_o,
  output logic mem_disable
);

  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam int WW = $clog2(WDOG_CYC + 1);
  localparam int GW = $clog2(GLITCH_CYC + 1);
  localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT_CYC - 1);
  localparam logic [WW-1:0] W_LAST = WW'(WDOG_CYC - 1);
  localparam logic [GW-1:0] G_LAST = GW'(GLITCH_CYC - 1);

  logic [2:0] sda_q, hi_q, lo_q, drv_hist;
  logic [GW-1:0] gcnt;
  logic [TW-1:0] tcnt;
  logic [WW-1:0] wcnt;
  logic sup_f, rst_act;
  logic sda_edge, hi_rise, lo_fall, mask, man_req, wd_to;

  // two-flop synchronisers plus an edge-detect stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_q    <= 3'b111;
      hi_q     <= 3'b000;
      lo_q     <= 3'b111;
      drv_hist <= 3'b111;
    end else begin
      sda_q    <= {sda_q[1:0], sda_in};
      hi_q     <= {hi_q[1:0], rst_hi_pad};
      lo_q     <= {lo_q[1:0], rst_lo_n_pad};
      drv_hist <= {drv_hist[1:0], rst_act};
    end
  end

  assign sda_edge    = sda_q[1] ^ sda_q[2];
  assign hi_rise     = hi_q[1] & ~hi_q[2];
  assign lo_fall     = ~lo_q[1] & lo_q[2];
  assign mask        = rst_act | (|drv_hist);
  assign man_req     = ~mask & (hi_rise | lo_fall);
  assign mem_disable = hi_q[1] | ~lo_q[1];

  // supply glitch filter: a new level must persist GLITCH_CYC cycles
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sup_f <= 1'b0;
      gcnt  <= '0;
    end else if (supply_ok == sup_f) begin
      gcnt <= '0;
    end else if (gcnt == G_LAST) begin
      sup_f <= supply_ok;
      gcnt  <= '0;
    end else begin
      gcnt <= gcnt + 1'b1;
    end
  end

  // watchdog
  assign wd_to = ~rst_act & ~sda_edge & (wcnt == W_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         wcnt <= '0;
    else if (rst_act | sda_edge | wd_to) wcnt <= '0;
    else                                 wcnt <= wcnt + 1'b1;
  end

  // reset state and timeout
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_act <= 1'b1;
      tcnt    <= '0;
    end else if (!sup_f || man_req || wd_to) begin
      rst_act <= 1'b1;
      tcnt    <= '0;
    end else if (rst_act) begin
      if (tcnt == T_LAST) begin
        rst_act <= 1'b0;
        tcnt    <= '0;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  assign rst_hi_o   = rst_act;
  assign rst_lo_n_o = ~rst_act;

  p_supply_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_f |=> (rst_hi_o && !rst_lo_n_o));

  p_release_timeout_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_hi_o) |-> ($past(tcnt) == T_LAST && sup_f));

  p_glitch_filter_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sup_f) |-> (sup_f == $past(supply_ok)));

  p_manual_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    man_req |=> (rst_hi_o && tcnt == '0));

  p_wdog_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wd_to |=> (rst_hi_o && !rst_lo_n_o));

  p_wdog_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_hi_o |=> (wcnt == '0));

  p_no_self_trigger_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_hi_o) |=> !man_req);

endmodule

// File: tb/rst_supervisor_test.sv
module rst_supervisor_test;
  localparam int T = 20;
  localparam int W = 60;
  localparam int G = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0;
  logic kick_en = 1'b0, kick_sda = 1'b1, man_sda = 1'b0;
  logic ext_hi = 1'b0, ext_lo = 1'b0;
  logic sda_in, rst_hi_pad, rst_lo_n_pad;
  logic rst_hi_o, rst_lo_n_o, mem_disable;
  int checks = 0, fails = 0, kcnt = 0;

  always #2 clk = ~clk;

  assign sda_in       = kick_sda ^ man_sda;
  assign rst_hi_pad   = rst_hi_o | ext_hi;
  assign rst_lo_n_pad = rst_lo_n_o & ~ext_lo;

  rst_supervisor #(.TIMEOUT_CYC(T), .WDOG_CYC(W), .GLITCH_CYC(G)) uut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .sda_in(sda_in),
    .rst_hi_pad(rst_hi_pad), .rst_lo_n_pad(rst_lo_n_pad),
    .rst_hi_o(rst_hi_o), .rst_lo_n_o(rst_lo_n_o), .mem_disable(mem_disable));

  always @(negedge clk) begin
    if (kick_en) begin
      kcnt = kcnt + 1;
      if (kcnt % 8 == 0) kick_sda = ~kick_sda;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic chk_rst(input logic exp, input string req, input string what);
    chk(rst_hi_o, exp, req, {what, " hi"});
    chk(rst_lo_n_o, ~exp, req, {what, " lo_n"});
  endtask

  task automatic t_reset_state;
    tick(2);
    chk_rst(1'b1, "R1", "during block reset");
    rst_n = 1'b1;
    tick(4);
    chk_rst(1'b1, "R1", "supply low");
    chk(mem_disable, 1'b1, "R11", "mem_disable with own reset");
  endtask

  task automatic t_powerup;
    supply_ok = 1'b1;
    kick_en = 1'b1;
    tick(G + T - 1);
    chk_rst(1'b1, "R2", "one edge before release");
    tick(1);
    chk_rst(1'b0, "R2", "release edge");
    tick(1);
    chk(mem_disable, 1'b1, "R11", "mem_disable one edge after release");
    tick(1);
    chk(mem_disable, 1'b0, "R11", "mem_disable two edges after release");
  endtask

  task automatic t_glitch_low;
    supply_ok = 1'b0;
    tick(G - 1);
    supply_ok = 1'b1;
    for (int i = 0; i < 2 * T; i++) begin
      tick(1);
      if (rst_hi_o) begin
        chk_rst(1'b0, "R4", "short dip");
        break;
      end
    end
    chk_rst(1'b0, "R4", "after short dip");
  endtask

  task automatic t_supply_fall;
    supply_ok = 1'b0;
    tick(G);
    chk_rst(1'b0, "R3", "one edge before assert");
    tick(1);
    chk_rst(1'b1, "R3", "assert edge");
    tick(5);
    supply_ok = 1'b1;
    tick(G - 1);
    supply_ok = 1'b0;
    tick(G + T + 5);
    chk_rst(1'b1, "R4", "short high pulse in supply-low reset");
    supply_ok = 1'b1;
    tick(G + T - 1);
    chk_rst(1'b1, "R2", "re-powerup before release");
    tick(1);
    chk_rst(1'b0, "R2", "re-powerup release");
  endtask

  task automatic t_manual_lo;
    tick(6);
    ext_lo = 1'b1;
    tick(2);
    chk_rst(1'b0, "R5", "before manual assert");
    chk(mem_disable, 1'b1, "R11", "mem_disable from held lo pin");
    tick(1);
    chk_rst(1'b1, "R5", "manual assert");
    tick(T - 1);
    chk_rst(1'b1, "R5", "before manual release");
    tick(1);
    chk_rst(1'b0, "R7", "release while pin held");
    tick(T);
    chk_rst(1'b0, "R7", "still released while pin held");
    chk(mem_disable, 1'b1, "R11", "mem_disable while pin held");
    ext_lo = 1'b0;
    tick(T + 5);
    chk_rst(1'b0, "R7", "inactive edge ignored");
    chk(mem_disable, 1'b0, "R11", "mem_disable after pin freed");
  endtask

  task automatic t_manual_hi;
    ext_hi = 1'b1;
    tick(1);
    ext_hi = 1'b0;
    tick(1);
    chk_rst(1'b0, "R6", "before manual assert");
    tick(1);
    chk_rst(1'b1, "R6", "manual assert from pulse");
    tick(T - 1);
    chk_rst(1'b1, "R6", "before release");
    tick(1);
    chk_rst(1'b0, "R6", "release");
    tick(5);
  endtask

  task automatic t_wd_kick;
    kick_en = 1'b0;
    tick(3);
    for (int i = 0; i < 4; i++) begin
      man_sda = ~man_sda;
      tick(W - 1);
      chk_rst(1'b0, "R9", man_sda ? "after rising kick" : "after falling kick");
    end
    man_sda = ~man_sda;
    tick(W + 2);
    chk_rst(1'b0, "R8", "one edge before timeout");
    tick(1);
    chk_rst(1'b1, "R8", "timeout");
    tick(T - 1);
    chk_rst(1'b1, "R12", "watchdog reset before release");
    tick(1);
    chk_rst(1'b0, "R12", "watchdog reset length");
  endtask

  task automatic t_wd_hold;
    supply_ok = 1'b0;
    tick(G + 1);
    chk_rst(1'b1, "R10", "supply low");
    tick(2 * W);
    supply_ok = 1'b1;
    tick(G + T);
    chk_rst(1'b0, "R10", "release after long reset");
    tick(W - 1);
    chk_rst(1'b0, "R10", "count cleared during reset");
    tick(1);
    chk_rst(1'b1, "R10", "timeout counted from release");
    kick_en = 1'b1;
    tick(T);
    chk_rst(1'b0, "R12", "release after second watchdog reset");
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_powerup();
        t_glitch_low();
        t_supply_fall();
        t_manual_lo();
        t_manual_hi();
        t_wd_kick();
        t_wd_hold();
      end
      begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule